// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block converts the settings of one memory-protection entry into an inclusive byte range. It takes the entry's two-bit matching mode, its address register and the address register of the entry just below it. It returns the lowest and highest byte addresses the entry covers, plus a flag that says whether the entry is active. Address registers hold a physical address divided by four. The outputs are two bits wider than the registers, so the rebuilt byte addresses never overflow.

The decoder is meant to sit beside the register file of a protection unit. It recomputes one entry's range each time that entry or its lower neighbour is written, so the permission checker compares against ready-made bounds. The result is registered, so it appears one clock after the inputs. In the naturally aligned mode, the region size comes from counting trailing ones in the address register.

Top module: `pmp_bounds_dec`

## Requirements
- R1: Outputs are registered with a latency of one clock: the inputs present at a rising edge set the outputs seen after that edge. While reset (`rst_n` low) is asserted, `rgn_valid_o`, `rgn_lo_o` and `rgn_hi_o` are all zero.
- R2: Mode code 0 (disabled) drives `rgn_valid_o` low. Codes 1 (top-of-range), 2 (four-byte) and 3 (aligned power-of-two) drive it high.
- R3: In mode 1, `rgn_lo_o` = neighbour address × 4 and `rgn_hi_o` = (own address × 4) − 1, taken modulo 2^(AW+2). An own address of zero therefore yields an all-ones upper bound.
- R4: In mode 1 with `first_entry_i` high, the neighbour address is treated as zero, so `rgn_lo_o` is 0 whatever `prev_addr_i` holds.
- R5: In mode 2, `rgn_lo_o` = own address × 4 and `rgn_hi_o` = `rgn_lo_o` + 3.
- R6: In mode 3, let t be the number of trailing one bits in the own address. Then `rgn_lo_o` = (address with its low t bits cleared) × 4 and `rgn_hi_o` = `rgn_lo_o` + 2^(t+3) − 1. For example, ...0 gives 8 bytes, ...01 gives 16 bytes and ...011 gives 32 bytes.
- R7: In mode 3, an all-ones address covers the entire space: `rgn_lo_o` = 0 and `rgn_hi_o` = 2^(AW+2) − 1.
- R8: Outputs are AW+2 bits wide and the top of the space is reached without wrap. In mode 2 the topmost address ends at 2^(AW+2) − 1, and in mode 3 the pattern 0111...1 spans 0 to 2^(AW+2) − 1.
- R9: `first_entry_i` and `prev_addr_i` have no effect on the outputs in modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Matching mode: 0 disabled, 1 top-of-range, 2 four-byte, 3 aligned power-of-two |
| first_entry_i | input | 1 | High when the entry is entry 0 and has no lower neighbour |
| cur_addr_i | input | AW | This entry's address register (byte address / 4) |
| prev_addr_i | input | AW | Lower neighbour's address register (byte address / 4) |
| rgn_valid_o | output | 1 | Entry is active |
| rgn_lo_o | output | AW+2 | Inclusive first byte address |
| rgn_hi_o | output | AW+2 | Inclusive last byte address |

## Verification
The bench builds the decoder with AW = 8, which gives 10-bit byte bounds. Every address register pattern, including all-ones and 0111_1111, can then be swept in the aligned power-of-two mode and compared against an arithmetic model. At this width the top-of-space wrap in the four-byte and top-of-range modes also falls on small, readable values. A table of hand-computed vectors covers the mixed-mode cases. It includes an inverted top-of-range pair and the neighbour-independence cases.

// File: rtl/pmp_bounds_pkg.sv
package pmp_bounds_pkg;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_mode_e;

endpackage

// File: rtl/pmp_tone_count.sv
// Counts the run of one bits starting at bit 0; returns AW when all bits are set.
module pmp_tone_count #(
    parameter int AW = 32,
    localparam int CW = $clog2(AW + 1)
) (
    input  logic [AW-1:0] vec_i,
    output logic [CW-1:0] ones_o
);
    always_comb begin
        ones_o = CW'(AW);
        for (int i = AW - 1; i >= 0; i--) begin
            if (!vec_i[i]) begin
                ones_o = CW'(i);
            end
        end
    end
endmodule

// File: rtl/pmp_napot_span.sv
// Builds the aligned power-of-two range from a trailing-ones count.
module pmp_napot_span #(
    parameter int AW = 32,
    localparam int CW = $clog2(AW + 1),
    localparam int OW = AW + 2
) (
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] ones_i,
    output logic [OW-1:0] lo_o,
    output logic [OW-1:0] hi_o
);
    // keep_m marks register bits 0..t: the t trailing ones plus the zero that ends them.
    logic [AW-1:0] keep_m;
    logic          whole_space;

    for (genvar g = 0; g < AW; g++) begin : g_mask
        assign keep_m[g] = (ones_i >= CW'(g));
    end

    assign whole_space = (ones_i == CW'(AW));

    always_comb begin
        if (whole_space) begin
            lo_o = '0;
            hi_o = '1;
        end else begin
            lo_o = {addr_i & ~keep_m, 2'b00};
            hi_o = {addr_i |  keep_m, 2'b11};
        end
    end
endmodule

// File: rtl/pmp_bounds_dec.sv
module pmp_bounds_dec
    import pmp_bounds_pkg::*;
#(
    parameter int AW = 32,
    localparam int OW = AW + 2,
    localparam int CW = $clog2(AW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_i,
    input  logic          first_entry_i,
    input  logic [AW-1:0] cur_addr_i,
    input  logic [AW-1:0] prev_addr_i,
    output logic          rgn_valid_o,
    output logic [OW-1:0] rgn_lo_o,
    output logic [OW-1:0] rgn_hi_o
);
    typedef struct packed {
        logic          valid;
        logic [OW-1:0] lo;
        logic [OW-1:0] hi;
    } span_t;

    span_t span_d, span_q;

    logic [CW-1:0] tone_cnt;
    logic [OW-1:0] napot_lo, napot_hi;
    logic [AW-1:0] base_below;
    match_mode_e   mode;

    assign mode = match_mode_e'(mode_i);

    pmp_tone_count #(.AW(AW)) u_tone (
        .vec_i  (cur_addr_i),
        .ones_o (tone_cnt)
    );

    pmp_napot_span #(.AW(AW)) u_napot (
        .addr_i (cur_addr_i),
        .ones_i (tone_cnt),
        .lo_o   (napot_lo),
        .hi_o   (napot_hi)
    );

    assign base_below = first_entry_i ? '0 : prev_addr_i;

    always_comb begin
        span_d = '0;
        unique case (mode)
            MATCH_TOR: begin
                span_d.valid = 1'b1;
                span_d.lo    = {base_below, 2'b00};
                span_d.hi    = {cur_addr_i, 2'b00} - OW'(1);
            end
            MATCH_NA4: begin
                span_d.valid = 1'b1;
                span_d.lo    = {cur_addr_i, 2'b00};
                span_d.hi    = {cur_addr_i, 2'b11};
            end
            MATCH_NAPOT: begin
                span_d.valid = 1'b1;
                span_d.lo    = napot_lo;
                span_d.hi    = napot_hi;
            end
            default: begin
                span_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span_q <= '0;
        end else begin
            span_q <= span_d;
        end
    end

    assign rgn_valid_o = span_q.valid;
    assign rgn_lo_o    = span_q.lo;
    assign rgn_hi_o    = span_q.hi;
endmodule

// File: rtl/pmp_bounds_dec_chk.sv
module pmp_bounds_dec_chk #(
    parameter int AW = 32,
    localparam int OW = AW + 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode_i,
    input logic          first_entry_i,
    input logic [AW-1:0] cur_addr_i,
    input logic [AW-1:0] prev_addr_i,
    input logic          rgn_valid_o,
    input logic [OW-1:0] rgn_lo_o,
    input logic [OW-1:0] rgn_hi_o
);
    logic [OW:0] span_len;
    assign span_len = {1'b0, rgn_hi_o} - {1'b0, rgn_lo_o} + (OW+1)'(1);

    // R2
    a_r2_off_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> !rgn_valid_o);
    a_r2_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'd0) |=> rgn_valid_o);
    // R3
    a_r3_tor_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && !first_entry_i) |=> (rgn_lo_o == {$past(prev_addr_i), 2'b00}));
    // R4
    a_r4_first_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && first_entry_i) |=> (rgn_lo_o == '0));
    // R5
    a_r5_na4_four_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2) |=> (rgn_hi_o - rgn_lo_o == OW'(3)));
    // R6
    a_r6_napot_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3) |=> ($countones(span_len) == 1 && rgn_lo_o[2:0] == 3'b000));
    // R7
    a_r7_all_ones_full: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && &cur_addr_i) |=> (rgn_lo_o == '0 && &rgn_hi_o));
endmodule

bind pmp_bounds_dec pmp_bounds_dec_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_i),
    .first_entry_i (first_entry_i),
    .cur_addr_i    (cur_addr_i),
    .prev_addr_i   (prev_addr_i),
    .rgn_valid_o   (rgn_valid_o),
    .rgn_lo_o      (rgn_lo_o),
    .rgn_hi_o      (rgn_hi_o)
);

// File: tb/tb_pmp_bounds_dec.sv
`timescale 1ns/1ps
module tb_pmp_bounds_dec;
    localparam int AW = 8;
    localparam int OW = AW + 2;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic          first_entry_i = 1'b0;
    logic [AW-1:0] cur_addr_i = '0;
    logic [AW-1:0] prev_addr_i = '0;
    logic          rgn_valid_o;
    logic [OW-1:0] rgn_lo_o, rgn_hi_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pmp_bounds_dec #(.AW(AW)) dut (.*);

    // {mode[2], first[1], cur[8], prev[8], valid[1], lo[10], hi[10]}
    localparam logic [39:0] VEC [NV] = '{
        {2'd1, 1'b1, 8'h10, 8'h55, 1'b1, 10'h000, 10'h03F}, // R4
        {2'd1, 1'b0, 8'h20, 8'h10, 1'b1, 10'h040, 10'h07F}, // R3
        {2'd1, 1'b0, 8'h00, 8'h00, 1'b1, 10'h000, 10'h3FF}, // R3 wrap
        {2'd1, 1'b0, 8'h10, 8'h30, 1'b1, 10'h0C0, 10'h03F}, // R3 inverted
        {2'd2, 1'b0, 8'h25, 8'h00, 1'b1, 10'h094, 10'h097}, // R5
        {2'd2, 1'b1, 8'h25, 8'h77, 1'b1, 10'h094, 10'h097}, // R9
        {2'd2, 1'b0, 8'hFF, 8'h00, 1'b1, 10'h3FC, 10'h3FF}, // R8
        {2'd3, 1'b0, 8'h20, 8'h00, 1'b1, 10'h080, 10'h087}, // R6
        {2'd3, 1'b0, 8'h21, 8'h00, 1'b1, 10'h080, 10'h08F}, // R6
        {2'd3, 1'b0, 8'h23, 8'h00, 1'b1, 10'h080, 10'h09F}, // R6
        {2'd3, 1'b0, 8'hB7, 8'h00, 1'b1, 10'h2C0, 10'h2FF}, // R6
        {2'd3, 1'b1, 8'hB7, 8'hEE, 1'b1, 10'h2C0, 10'h2FF}, // R9
        {2'd3, 1'b0, 8'h7F, 8'h00, 1'b1, 10'h000, 10'h3FF}, // R8
        {2'd3, 1'b0, 8'hFF, 8'h00, 1'b1, 10'h000, 10'h3FF}, // R7
        {2'd0, 1'b0, 8'h12, 8'h34, 1'b0, 10'h000, 10'h000}  // R2
    };

    task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic f, input logic [AW-1:0] c, input logic [AW-1:0] p);
        @(negedge clk);
        mode_i = m; first_entry_i = f; cur_addr_i = c; prev_addr_i = p;
        @(negedge clk);
    endtask

    function automatic logic [2*OW-1:0] napot_model(input logic [AW-1:0] a);
        int t, base, hi;
        t = 0;
        while (t < AW && a[t]) t++;
        if (t == AW) return {OW'(0), {OW{1'b1}}};
        base = ((int'(a) >> t) << t) * 4;
        hi = base + (1 << (t + 3)) - 1;
        return {OW'(base), OW'(hi)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with active inputs applied during reset
        mode_i = 2'd2; cur_addr_i = 8'h40;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", OW'(rgn_valid_o), OW'(0));
        check("R1 lo in reset", rgn_lo_o, '0);
        check("R1 hi in reset", rgn_hi_o, '0);
        rst_n = 1'b1;

        foreach (VEC[k]) begin
            drive(VEC[k][39:38], VEC[k][37], VEC[k][36:29], VEC[k][28:21]);
            check($sformatf("R2 valid vec %0d", k), OW'(rgn_valid_o), OW'(VEC[k][20]));
            if (VEC[k][20]) begin
                check($sformatf("R3-6 lo vec %0d", k), rgn_lo_o, VEC[k][19:10]);
                check($sformatf("R3-6 hi vec %0d", k), rgn_hi_o, VEC[k][9:0]);
            end
        end

        // R1: one-cycle latency, outputs hold until the next edge
        drive(2'd2, 1'b0, 8'h01, 8'h00);
        @(negedge clk);
        mode_i = 2'd2; cur_addr_i = 8'h02;
        #1;
        check("R1 hold before edge", rgn_lo_o, 10'h004);
        @(negedge clk);
        check("R1 update after edge", rgn_lo_o, 10'h008);

        // R6 R7 R8: full sweep of the aligned power-of-two mode
        for (int a = 0; a < (1 << AW); a++) begin
            logic [2*OW-1:0] e;
            e = napot_model(AW'(a));
            drive(2'd3, a[0], AW'(a), AW'(~a));
            check($sformatf("R6 napot lo 0x%0h", a), rgn_lo_o, e[2*OW-1:OW]);
            check($sformatf("R6 napot hi 0x%0h", a), rgn_hi_o, e[OW-1:0]);
        end

        // R5 R9: four-byte mode sweep with a varying neighbour
        for (int a = 0; a < (1 << AW); a += 17) begin
            drive(2'd2, 1'b1, AW'(a), AW'(a * 3));
            check("R5 na4 lo", rgn_lo_o, OW'(a * 4));
            check("R5 na4 hi", rgn_hi_o, OW'(a * 4 + 3));
        end

        // R1: reset asserted mid-run clears outputs
        drive(2'd3, 1'b0, 8'hFF, 8'h00);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", rgn_hi_o, '0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule